// File: doc/BRIEF.md
# Flash Toggle-Bit Status Poller

This controller sits on the host side of a parallel NOR flash and decides when an embedded program or erase operation inside the device has ended. After a start pulse it issues status reads on a simple request/acknowledge bus. It watches two bits of each returned status byte. Bit 6 flips on every read while the device is busy. Bit 5 rises when the device's internal time limit has been exceeded.

When two successive reads show the same bit 6, the operation has ended and the controller reports success. While bit 6 keeps flipping and bit 5 stays low, polling continues. If bit 6 is flipping and bit 5 is high, the controller takes one more fresh pair of reads before it decides. This catches a device that stopped toggling at the same moment the timeout flag rose.

A failure leaves the device in status mode. In that case the controller writes the command byte 0xF0 to put the device back in array-read mode, and only then raises done. Polling can be interrupted with an abandon input. When the abandon input is released, polling always restarts from a fresh pair of reads. A parameter sets the largest number of status reads per attempt. When it is used up, the controller fails the operation.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset, busy_o, done_o and bus_req_o are low. A start_i pulse while idle raises busy_o on the next cycle and begins status reads at STATUS_ADDR. A start_i pulse while busy_o is high has no effect on the run in progress.
- R2: Once raised, bus_req_o stays high, with bus_we_o and bus_addr_o stable, until the cycle in which bus_ack_i is high. bus_rdata_i is taken in that cycle. Every transfer targets STATUS_ADDR.
- R3: The first read of each pair never produces a decision. Its bit 6 is only stored, so a run always takes at least two status reads.
- R4: A compared read whose bit 6 equals the stored bit 6 ends the run with done_o and pass_o high, and no write is issued.
- R5: A compared read whose bit 6 differs while bit 5 is low continues polling. Each new read is compared with the read just before it.
- R6: A compared read whose bit 6 differs while bit 5 is high starts a fresh pair of reads. On that re-check, equal bit 6 values give success and differing values give failure, whatever bit 5 shows.
- R7: On failure the block writes data 0xF0 (bus_we_o high) to STATUS_ADDR. done_o rises with pass_o low only after that write is acknowledged.
- R8: done_o is high for exactly one cycle, and busy_o falls in that same cycle. pass_o keeps its value until the next accepted start.
- R9: If the MAX_POLLS-th status read of an attempt does not complete the run, the block takes the failure path of R7.
- R10: If abandon_i is high when a status read is acknowledged, that read is discarded. The bus then stays idle while busy_o stays high. When abandon_i goes low, polling restarts with a fresh pair of reads and a fresh read budget, and no stored value is reused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (pulse) |
| abandon_i | input | 1 | Pause polling; resume from the start on release |
| busy_o | output | 1 | Polling run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Outcome of the last run (1 = success) |
| bus_req_o | output | 1 | Bus transfer request |
| bus_we_o | output | 1 | Transfer is a write |
| bus_addr_o | output | ADDR_W | Transfer address |
| bus_wdata_o | output | 8 | Write data |
| bus_ack_i | input | 1 | Transfer acknowledge; read data valid |
| bus_rdata_i | input | 8 | Read data (status byte) |

## Verification
The hardest case to reach from the ports is the re-check after the timeout flag rises. The bench has to line up bit 6 stopping, or not stopping, with the exact read on which bit 5 rises. A behavioural flash model in the bench flips bit 6 for a set number of reads and raises bit 5 from a set read index. Directed runs place both events on the same read and on neighbouring reads. Randomised pairs of these two indices then sweep the remaining orderings, including exhaustion of the read budget, and also the abandon-and-resume path.

// File: rtl/toggle_poll_pkg.sv
package toggle_poll_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned TOG_POS  = 6;
  localparam int unsigned TMO_POS  = 5;
  localparam logic [STAT_W-1:0] RESET_CMD = 8'hF0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,   // first read of a pair: store only
    ST_NEXT,    // compared read
    ST_PAUSE,
    ST_CLEAR    // reset-command write
  } poll_state_e;
endpackage

// File: rtl/tp_toggle_track.sv
module tp_toggle_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic load_i,
  input  logic tog_bit_i,
  output logic valid_o,
  output logic toggled_o
);
  logic prev_q;
  logic valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (clear_i) begin
      prev_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      prev_q  <= tog_bit_i;
      valid_q <= 1'b1;
    end
  end

  assign valid_o   = valid_q;
  assign toggled_o = valid_q && (tog_bit_i != prev_q);
endmodule

// File: rtl/tp_poll_budget.sv
module tp_poll_budget #(
  parameter int unsigned MAX_POLLS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  output logic last_o
);
  localparam int unsigned CNT_W = $clog2(MAX_POLLS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_POLLS - 1);
  localparam logic [CNT_W-1:0] CAP      = CNT_W'(MAX_POLLS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clear_i)                cnt_q <= '0;
    else if (step_i && cnt_q != CAP) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = step_i && (cnt_q == LAST_IDX);

  p_step_in_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !clear_i |-> cnt_q < CAP);
endmodule

// File: rtl/tp_bus_drive.sv
module tp_bus_drive import toggle_poll_pkg::*; #(
  parameter int unsigned ADDR_W = 20,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = '0
) (
  input  poll_state_e        st_i,
  output logic               req_o,
  output logic               we_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [STAT_W-1:0]  wdata_o
);
  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    addr_o  = STATUS_ADDR;
    wdata_o = '0;
    unique case (st_i)
      ST_FIRST, ST_NEXT: req_o = 1'b1;
      ST_CLEAR: begin
        req_o   = 1'b1;
        we_o    = 1'b1;
        wdata_o = RESET_CMD;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl import toggle_poll_pkg::*; #(
  parameter int unsigned ADDR_W = 20,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = '0,
  parameter int unsigned MAX_POLLS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abandon_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [7:0]        bus_rdata_i
);
  poll_state_e st_q, st_d;
  logic recheck_q, rck_set, rck_clr;
  logic done_q, pass_q;
  logic trk_load, trk_clear, trk_valid, toggled;
  logic bud_clear, bud_step, bud_last;
  logic fin_ok, fin_fail, start_take;
  logic rd_ack;
  logic unused_rdata;

  assign unused_rdata = ^{bus_rdata_i[7], bus_rdata_i[4:0]};
  assign rd_ack   = bus_ack_i && (st_q == ST_FIRST || st_q == ST_NEXT);
  assign bud_step = rd_ack;

  tp_toggle_track u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (trk_clear),
    .load_i    (trk_load),
    .tog_bit_i (bus_rdata_i[TOG_POS]),
    .valid_o   (trk_valid),
    .toggled_o (toggled)
  );

  tp_poll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (bud_clear),
    .step_i  (bud_step),
    .last_o  (bud_last)
  );

  tp_bus_drive #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_drive (
    .st_i    (st_q),
    .req_o   (bus_req_o),
    .we_o    (bus_we_o),
    .addr_o  (bus_addr_o),
    .wdata_o (bus_wdata_o)
  );

  always_comb begin
    st_d       = st_q;
    trk_load   = 1'b0;
    trk_clear  = 1'b0;
    bud_clear  = 1'b0;
    rck_set    = 1'b0;
    rck_clr    = 1'b0;
    fin_ok     = 1'b0;
    fin_fail   = 1'b0;
    start_take = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        start_take = 1'b1;
        trk_clear  = 1'b1;
        bud_clear  = 1'b1;
        rck_clr    = 1'b1;
        st_d       = ST_FIRST;
      end
      ST_FIRST: if (bus_ack_i) begin
        if (abandon_i)     st_d = ST_PAUSE;
        else if (bud_last) st_d = ST_CLEAR;
        else begin
          trk_load = 1'b1;
          st_d     = ST_NEXT;
        end
      end
      ST_NEXT: if (bus_ack_i) begin
        if (abandon_i) st_d = ST_PAUSE;
        else if (!toggled) begin
          fin_ok = 1'b1;
          st_d   = ST_IDLE;
        end
        else if (recheck_q || bud_last) st_d = ST_CLEAR;
        else if (bus_rdata_i[TMO_POS]) begin
          rck_set = 1'b1;     // timeout seen: confirm with a fresh pair
          st_d    = ST_FIRST;
        end
        else trk_load = 1'b1; // slide: compare next read with this one
      end
      ST_PAUSE: if (!abandon_i) begin
        trk_clear = 1'b1;
        bud_clear = 1'b1;
        rck_clr   = 1'b1;
        st_d      = ST_FIRST;
      end
      ST_CLEAR: if (bus_ack_i) begin
        fin_fail = 1'b1;
        st_d     = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      recheck_q <= 1'b0;
      done_q    <= 1'b0;
      pass_q    <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin_ok || fin_fail;
      if (rck_clr)      recheck_q <= 1'b0;
      else if (rck_set) recheck_q <= 1'b1;
      if (start_take)   pass_q <= 1'b0;
      else if (fin_ok)  pass_q <= 1'b1;
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign pass_o = pass_q;

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_we_o) && $stable(bus_addr_o));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_not_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_pass_via_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && pass_o |-> $past(bus_req_o && !bus_we_o && bus_ack_i));
  p_fail_after_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !pass_o |-> $past(bus_req_o && bus_we_o && bus_ack_i && bus_wdata_o == RESET_CMD));
  p_compare_has_ref_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_NEXT |-> trk_valid);
  p_budget_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bud_last && !abandon_i && !(st_q == ST_NEXT && !toggled) |=> st_q == ST_CLEAR);
  p_pause_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_PAUSE |-> !bus_req_o && busy_o);
  p_pause_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_PAUSE && !abandon_i |=> st_q == ST_FIRST && !trk_valid);
endmodule

// File: tb/toggle_poll_ctrl_bench.sv
`timescale 1ns/1ps
module toggle_poll_ctrl_bench;
  localparam int AW = 12;
  localparam int LIMIT = 20;
  localparam logic [AW-1:0] SADDR = 12'h555;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic start = 1'b0, abandon = 1'b0;
  logic busy, done, pass;
  logic req, we, ack = 1'b0;
  logic [AW-1:0] addr;
  logic [7:0] wdata, rdata = 8'h00;

  toggle_poll_ctrl #(.ADDR_W(AW), .STATUS_ADDR(SADDR), .MAX_POLLS(LIMIT)) u_toggle_poll_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abandon_i(abandon),
    .busy_o(busy), .done_o(done), .pass_o(pass),
    .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
    .bus_ack_i(ack), .bus_rdata_i(rdata)
  );

  // behavioural flash: bit 6 flips on each of the first mdl_n reads, bit 5 high from read mdl_d5
  int mdl_n = 0, mdl_d5 = 0;
  logic mdl_clr = 1'b0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [7:0] wr_data = 8'h00;
  logic dq6 = 1'b0, addr_bad = 1'b0;

  always @(posedge clk) begin : flash_model
    logic nv;
    ack <= 1'b0;
    if (mdl_clr) begin
      rd_cnt <= 0; wr_cnt <= 0; dq6 <= 1'b0; wr_data <= 8'h00; addr_bad <= 1'b0;
    end else if (req && !ack) begin
      ack <= 1'b1;
      if (addr != SADDR) addr_bad <= 1'b1;
      if (we) begin
        wr_cnt  <= wr_cnt + 1;
        wr_data <= wdata;
        rdata   <= 8'h00;
      end else begin
        nv = (rd_cnt < mdl_n) ? ~dq6 : dq6;
        dq6    <= nv;
        rd_cnt <= rd_cnt + 1;
        rdata  <= {~nv, nv, (mdl_d5 != 0 && rd_cnt + 1 >= mdl_d5), 5'(rd_cnt)};
      end
    end
  end

  int checks = 0, fails = 0, cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL R1 watchdog actual=%0d expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit dq6_at(input int n, input int i);
    return ((i < n) ? i : n) % 2 == 1;
  endfunction

  // expected outcome from the decision rules
  function automatic void predict(input int n, input int d5, output bit ok, output int reads);
    bit first = 1'b1, rck = 1'b0, prev = 1'b0, v, t5;
    ok = 1'b0; reads = LIMIT;
    for (int i = 1; i <= LIMIT; i++) begin
      v  = dq6_at(n, i);
      t5 = (d5 != 0 && i >= d5);
      if (first) begin
        if (i == LIMIT) begin reads = i; return; end
        prev = v; first = 1'b0;
      end else if (v == prev) begin
        ok = 1'b1; reads = i; return;
      end else if (rck || i == LIMIT) begin
        reads = i; return;
      end else if (t5) begin
        rck = 1'b1; first = 1'b1;
      end else prev = v;
    end
  endfunction

  task automatic load_model(input int n, input int d5);
    mdl_n = n; mdl_d5 = d5; mdl_clr = 1'b1;
    tick();
    mdl_clr = 1'b0;
  endtask

  task automatic wait_done(input bit poke, output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      if (poke && k == 5) start = 1'b1;
      if (poke && k == 6) start = 1'b0;
      tick();
      if (done) begin seen = 1'b1; break; end
    end
    start = 1'b0;
  endtask

  task automatic finish_checks(input string tag, input bit exp_ok, input int exp_rd);
    check(pass == exp_ok, tag, pass, exp_ok);
    check(!busy, "R8 busy at done", busy, 0);
    check(rd_cnt == exp_rd, "R5 status read count", rd_cnt, exp_rd);
    check(wr_cnt == (exp_ok ? 0 : 1), "R7 reset writes", wr_cnt, exp_ok ? 0 : 1);
    if (!exp_ok) check(wr_data == 8'hF0, "R7 reset data", wr_data, 8'hF0);
    check(!addr_bad, "R2 address", addr_bad, 0);
    tick();
    check(!done, "R8 done width", done, 0);
    check(pass == exp_ok, "R8 pass held", pass, exp_ok);
  endtask

  task automatic run_op(input int n, input int d5, input bit poke, input string tag);
    bit exp_ok, seen;
    int exp_rd;
    predict(n, d5, exp_ok, exp_rd);
    load_model(n, d5);
    start = 1'b1;
    tick();
    start = 1'b0;
    check(busy, "R1 busy after start", busy, 1);
    wait_done(poke, seen);
    check(seen, "R1 done seen", seen, 1);
    finish_checks(tag, exp_ok, exp_rd);
  endtask

  initial begin
    int unused_seed;
    bit seen;
    unused_seed = $urandom(32'd20240611);
    repeat (3) tick();
    check(!busy && !done && !req, "R1 reset state", {busy, done, req}, 0);
    rst_n = 1'b1;
    tick();

    run_op(0, 0, 1'b0, "R3 two reads minimum");
    run_op(3, 0, 1'b0, "R4 normal completion");
    run_op(7, 0, 1'b0, "R5 long toggling");
    run_op(4, 5, 1'b0, "R4 stop as bit5 rises");
    run_op(5, 5, 1'b0, "R6 recheck passes");
    run_op(6, 5, 1'b0, "R6 recheck stop on second");
    run_op(100, 6, 1'b0, "R6 recheck fails");
    run_op(1, 1, 1'b0, "R6 early bit5");
    run_op(100, 0, 1'b0, "R9 budget exhausted");
    run_op(100, 0, 1'b1, "R1 start while busy ignored");

    // abandon and resume (R10)
    load_model(100, 0);
    start = 1'b1; tick(); start = 1'b0;
    while (rd_cnt < 3) tick();
    abandon = 1'b1;
    repeat (10) tick();
    check(busy, "R10 busy while paused", busy, 1);
    check(!req, "R10 bus idle while paused", req, 0);
    check(!done, "R10 no done while paused", done, 0);
    load_model(0, 0);
    repeat (3) tick();
    check(rd_cnt == 0, "R10 no reads while paused", rd_cnt, 0);
    abandon = 1'b0;
    wait_done(1'b0, seen);
    check(seen, "R10 done after resume", seen, 1);
    finish_checks("R10 resume restarts pair", 1'b1, 2);

    for (int r = 0; r < 25; r++) begin
      int n, d5;
      n  = $urandom_range(0, 24);
      d5 = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(1, 24);
      run_op(n, d5, 1'b0, "R6 random outcome");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule